// File: doc/BRIEF.md
# Latched Four-Phase Branch Selector

This block routes a four-phase (return-to-zero) request to one of two downstream branches, chosen by a Boolean condition. A request arriving on `in_req` is copied onto `t_req` when the condition is high or onto `f_req` when it is low. The acknowledge from the chosen branch is merged back onto `in_ack`. Every handshake wire is modelled as a level that is sampled on each rising clock edge.

The block samples the condition in the cycle where the request is first seen high. It holds that value until the whole handshake has returned to zero. While no handshake is in progress, the condition passes straight through. Once a request is accepted, later work in the sequence can change the condition without sending control down the other branch. An active-low master clear returns the block to rest.

The controller has four named states:
- `ST_IDLE`: the condition passes through and no request is driven.
- `ST_REQ`: the chosen branch request is high and the block is waiting for that branch's acknowledge.
- `ST_ACK`: `in_ack` is high and the block is waiting for `in_req` to fall.
- `ST_RTZ`: the branch request has dropped and the block is waiting for the branch acknowledge to fall.

The transitions are:
- `ST_IDLE`→`ST_REQ` on `in_req`.
- `ST_REQ`→`ST_ACK` on the chosen acknowledge.
- `ST_ACK`→`ST_RTZ` on `in_req` low.
- `ST_RTZ`→`ST_IDLE` on the chosen acknowledge low.

Top module: `branch_steer`

## Requirements
- R1: One cycle after `in_req` is first sampled high in `ST_IDLE`, exactly one branch request is high: `t_req` if `cond` was 1, `f_req` if `cond` was 0. Both branch requests are never high together.
- R2: While idle the condition is transparent. Only the value of `cond` at the edge that accepts the request decides the branch, and earlier toggles have no effect.
- R3: A change of `cond` while a handshake is in progress never moves the request to the other branch, from acceptance through the return-to-zero phase.
- R4: Four-phase sequencing works as follows:
  - `in_ack` rises one cycle after the chosen branch acknowledge is sampled high.
  - The branch request falls one cycle after `in_req` is sampled low.
  - `in_ack` falls one cycle after the chosen acknowledge is sampled low.
- R5: `in_ack` follows only the chosen branch's acknowledge. An acknowledge on the unselected branch while a branch request is high is an illegal environment event and is flagged.
- R6: A branch acknowledge arriving while no request is outstanding is ignored: `in_ack`, `t_req` and `f_req` stay low.
- R7: While `clr_n` is low, `in_ack`, `t_req` and `f_req` are low at once and the held condition is cleared. After release, the next request follows the current `cond`.
- R8: A new `in_req` raised before the previous branch acknowledge has fallen is not accepted. It is accepted one cycle after the block returns to `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| clr_n | input | 1 | Master clear, active low, asynchronous |
| cond | input | 1 | Branch condition (1 = true branch) |
| in_req | input | 1 | Incoming request |
| in_ack | output | 1 | Merged acknowledge to the requester |
| t_req | output | 1 | True-branch request |
| t_ack | input | 1 | True-branch acknowledge |
| f_req | output | 1 | False-branch request |
| f_ack | input | 1 | False-branch acknowledge |

## Verification
The hardest situation to reach is a condition flip that lands in each phase of an accepted handshake, including the return-to-zero tail where the request has dropped but the acknowledge is still high. The bench sweeps both starting condition values, with and without a flip right after acceptance. It also varies the acknowledge delay and the release delay, so the flipped condition is present for different lengths of every state. A separate sequence raises a fresh request during the return-to-zero tail, to show that the block waits for the acknowledge to clear before taking it.

// File: rtl/branch_steer_pkg.sv
package branch_steer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_ACK  = 2'd2,
        ST_RTZ  = 2'd3
    } steer_state_e;
endpackage

// File: rtl/branch_cond_hold.sv
module branch_cond_hold #(
    parameter logic CLEAR_VALUE = 1'b0
) (
    input  logic clk,
    input  logic clr_n,
    input  logic open_i,
    input  logic cond_i,
    output logic sel_o
);
    logic sel_q;

    // Tracks the condition while open; keeps the captured value while closed.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      sel_q <= CLEAR_VALUE;
        else if (open_i) sel_q <= cond_i;
    end

    assign sel_o = open_i ? cond_i : sel_q;
endmodule

// File: rtl/branch_steer_fsm.sv
module branch_steer_fsm
    import branch_steer_pkg::*;
(
    input  logic         clk,
    input  logic         clr_n,
    input  logic         in_req,
    input  logic         sel,
    input  logic         t_ack,
    input  logic         f_ack,
    output steer_state_e state_o,
    output logic         in_ack,
    output logic         t_req,
    output logic         f_req
);
    steer_state_e state_q, state_d;
    logic         chosen_ack;

    assign chosen_ack = sel ? t_ack : f_ack;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_req)      state_d = ST_REQ;
            ST_REQ:  if (chosen_ack)  state_d = ST_ACK;
            ST_ACK:  if (!in_req)     state_d = ST_RTZ;
            ST_RTZ:  if (!chosen_ack) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        logic drive;
        drive  = 1'b0;
        in_ack = 1'b0;
        unique case (state_q)
            ST_IDLE: begin drive = 1'b0; in_ack = 1'b0; end
            ST_REQ:  begin drive = 1'b1; in_ack = 1'b0; end
            ST_ACK:  begin drive = 1'b1; in_ack = 1'b1; end
            ST_RTZ:  begin drive = 1'b0; in_ack = 1'b1; end
        endcase
        t_req = drive &  sel;
        f_req = drive & ~sel;
    end

    assign state_o = state_q;
endmodule

// File: rtl/branch_steer.sv
module branch_steer
    import branch_steer_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  logic cond,
    input  logic in_req,
    output logic in_ack,
    output logic t_req,
    input  logic t_ack,
    output logic f_req,
    input  logic f_ack
);
    steer_state_e state;
    logic         sel;
    logic         hold_open;

    assign hold_open = (state == ST_IDLE);

    branch_cond_hold #(.CLEAR_VALUE(1'b0)) u_hold (
        .clk    (clk),
        .clr_n  (clr_n),
        .open_i (hold_open),
        .cond_i (cond),
        .sel_o  (sel)
    );

    branch_steer_fsm u_fsm (
        .clk     (clk),
        .clr_n   (clr_n),
        .in_req  (in_req),
        .sel     (sel),
        .t_ack   (t_ack),
        .f_ack   (f_ack),
        .state_o (state),
        .in_ack  (in_ack),
        .t_req   (t_req),
        .f_req   (f_req)
    );
endmodule

// File: rtl/branch_steer_chk.sv
module branch_steer_chk (
    input logic clk,
    input logic clr_n,
    input logic in_req,
    input logic in_ack,
    input logic t_req,
    input logic t_ack,
    input logic f_req,
    input logic f_ack
);
    AST_ONE_BRANCH: assert property (@(posedge clk) disable iff (!clr_n) !(t_req && f_req)); // R1
    AST_REQ_FROM_IN: assert property (@(posedge clk) disable iff (!clr_n) ($rose(t_req) || $rose(f_req)) |-> $past(in_req)); // R1
    AST_T_FROZEN: assert property (@(posedge clk) disable iff (!clr_n) (t_req && in_req) |=> !f_req); // R3
    AST_F_FROZEN: assert property (@(posedge clk) disable iff (!clr_n) (f_req && in_req) |=> !t_req); // R3
    AST_ACK_WITH_REQ: assert property (@(posedge clk) disable iff (!clr_n) $rose(in_ack) |-> (t_req || f_req)); // R4
    AST_ACK_RTZ: assert property (@(posedge clk) disable iff (!clr_n) $fell(in_ack) |-> !$past(t_ack || f_ack)); // R4
    AST_WRONG_T_ACK: assert property (@(posedge clk) disable iff (!clr_n) f_req |-> !t_ack); // R5
    AST_WRONG_F_ACK: assert property (@(posedge clk) disable iff (!clr_n) t_req |-> !f_ack); // R5

    always @(posedge clk) begin
        if (!clr_n) begin
            AST_CLEAR_QUIET: assert (!in_ack && !t_req && !f_req); // R7
        end
    end
endmodule

bind branch_steer branch_steer_chk u_chk (
    .clk    (clk),
    .clr_n  (clr_n),
    .in_req (in_req),
    .in_ack (in_ack),
    .t_req  (t_req),
    .t_ack  (t_ack),
    .f_req  (f_req),
    .f_ack  (f_ack)
);

// File: tb/branch_steer_bench.sv
module branch_steer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic clk = 1'b0;
    logic clr_n, cond, in_req, t_ack, f_ack;
    logic in_ack, t_req, f_req;
    int   n_vec = 0;
    int   n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_steer u_branch_steer (
        .clk(clk), .clr_n(clr_n), .cond(cond), .in_req(in_req), .in_ack(in_ack),
        .t_req(t_req), .t_ack(t_ack), .f_req(f_req), .f_ack(f_ack)
    );

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s {in_ack,t_req,f_req} actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] outs(input logic ack, input logic on, input logic c);
        return {ack, on & c, on & ~c};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_ack(input logic c, input logic v);
        if (c) t_ack = v; else f_ack = v;
    endtask

    // One full handshake; cond may flip right after acceptance.
    task automatic handshake(input logic c0, input logic flip, input int d_ack, input int d_rel);
        for (int k = 0; k < 3; k++) begin cond = (k % 2 == 0) ? ~c0 : c0; tick(); end // R2 pre-toggles
        cond = c0; in_req = 1'b1;
        tick();
        chk("R1", {in_ack, t_req, f_req}, outs(1'b0, 1'b1, c0));
        if (flip) cond = ~c0;
        for (int k = 0; k < d_ack; k++) begin
            tick();
            chk("R3", {in_ack, t_req, f_req}, outs(1'b0, 1'b1, c0));
        end
        set_ack(c0, 1'b1);
        tick();
        chk("R5", {in_ack, t_req, f_req}, outs(1'b1, 1'b1, c0));
        for (int k = 0; k < d_rel; k++) begin
            tick();
            chk("R3", {in_ack, t_req, f_req}, outs(1'b1, 1'b1, c0));
        end
        in_req = 1'b0;
        tick();
        chk("R4", {in_ack, t_req, f_req}, 3'b100);
        set_ack(c0, 1'b0);
        tick();
        chk("R4", {in_ack, t_req, f_req}, 3'b000);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        clr_n = 1'b0; cond = 1'b0; in_req = 1'b0; t_ack = 1'b0; f_ack = 1'b0;
        tick(); tick();
        chk("R7", {in_ack, t_req, f_req}, 3'b000);
        clr_n = 1'b1;
        tick();

        // R6: stray acknowledges while idle
        t_ack = 1'b1; f_ack = 1'b1; tick();
        chk("R6", {in_ack, t_req, f_req}, 3'b000);
        tick();
        chk("R6", {in_ack, t_req, f_req}, 3'b000);
        t_ack = 1'b0; f_ack = 1'b0; tick();

        // R1..R5 sweep
        for (int c = 0; c < 2; c++)
            for (int fl = 0; fl < 2; fl++)
                for (int da = 0; da < 4; da++)
                    for (int dr = 0; dr < 3; dr++)
                        handshake(c[0], fl[0], da, dr);

        // R8: new request while the acknowledge is still high in return-to-zero
        cond = 1'b1; in_req = 1'b1; tick();
        t_ack = 1'b1; tick();
        in_req = 1'b0; tick();
        chk("R8", {in_ack, t_req, f_req}, 3'b100);
        cond = 1'b0; in_req = 1'b1; tick();
        chk("R8", {in_ack, t_req, f_req}, 3'b100);
        tick();
        chk("R8", {in_ack, t_req, f_req}, 3'b100);
        t_ack = 1'b0; tick();
        chk("R8", {in_ack, t_req, f_req}, 3'b000);
        tick();
        chk("R8", {in_ack, t_req, f_req}, 3'b001);
        f_ack = 1'b1; tick();
        in_req = 1'b0; tick();
        f_ack = 1'b0; tick();
        chk("R8", {in_ack, t_req, f_req}, 3'b000);

        // R7: clear in the middle of an acknowledged true-branch handshake
        cond = 1'b1; in_req = 1'b1; tick();
        t_ack = 1'b1; tick();
        chk("R7", {in_ack, t_req, f_req}, 3'b110);
        clr_n = 1'b0; #1;
        chk("R7", {in_ack, t_req, f_req}, 3'b000);
        in_req = 1'b0; t_ack = 1'b0; tick();
        clr_n = 1'b1; tick();
        chk("R7", {in_ack, t_req, f_req}, 3'b000);
        cond = 1'b0; in_req = 1'b1; tick();
        chk("R7", {in_ack, t_req, f_req}, 3'b001);
        f_ack = 1'b1; tick();
        in_req = 1'b0; tick();
        f_ack = 1'b0; tick();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule